// File: doc/BRIEF.md
# Flash row-write sequencing controller

This block stages a full program-memory row in a byte-wide holding buffer and then commits that row to a behavioural array in one timed, guarded operation. The processor loads the buffer one byte per write. The low bits of a shared address pointer choose the buffer slot. A buffer write never touches the array. Programming is done a whole row at a time and never a single byte at a time.

A commit starts only after a two-byte key has been written to the unlock port and the control write that follows it sets both the start bit and the enable bit. At that moment the upper pointer bits choose the target row. The controller raises a stall for a fixed number of cycles set by a parameter. It writes the row when that timer expires, drops busy, and pulses done. The buffer is not cleared afterwards, so bytes that are not rewritten are programmed again by the next commit. The array model counts how many times each byte has been programmed and flags a third program, since an erase is not modelled.

Top module: `flash_row_writer`

## Requirements
- R1: A buffer write stores `buf_data` in the slot chosen by `ptr[5:0]`, and the array contents do not change.
- R2: Unlock writes of 55h and then AAh, followed directly by a control write with `ctl_wr`=1 and `ctl_wren`=1, start a commit. `busy` and `stall` are 1 from the next cycle.
- R3: A start request (`ctl_wr`=1) is ignored and `seq_err` is set and held until reset in any of these cases: the unlock key is broken (a wrong byte, or AAh without a 55h just before it), a buffer write or another control write comes between the key and the request, or `ctl_wren`=0.
- R4: `busy` and `stall` stay high for exactly PROG_CYCLES cycles. `done` is high for one cycle, which is the first cycle in which `busy` is low again.
- R5: When `done` is high, every byte of the row chosen by `ptr[8:6]` at the start request equals the holding buffer, and `rd_data` shows the array byte at `rd_addr`. The byte index is `rd_addr[5:0]` and the row is `rd_addr[8:6]`.
- R6: The holding buffer keeps its contents across a commit. A later commit with no new buffer writes programs the same bytes.
- R7: While `busy` is high, buffer writes, control writes and unlock writes are ignored. The commit length does not change, and an unlock written during a commit does not arm a later start.
- R8: A byte that is programmed a third time without an erase sets `overprog`, which stays set until reset.
- R9: After reset, `busy`, `stall`, `done`, `seq_err` and `overprog` are 0. Every array byte and every holding-buffer byte is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr | input | ADDR_W | Address pointer: the low bits select the buffer slot and the high bits select the row |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_data | input | 8 | Byte to store in the buffer |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wren | input | 1 | Write-enable bit of the control write |
| ctl_wr | input | 1 | Start-commit bit of the control write |
| key_we | input | 1 | Unlock register write strobe |
| key_data | input | 8 | Unlock byte |
| rd_addr | input | ADDR_W | Array observation address |
| rd_data | output | 8 | Array byte at rd_addr |
| stall | output | 1 | Processor stall during a commit |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle pulse when a commit completes |
| seq_err | output | 1 | Sticky flag for a rejected start request |
| overprog | output | 1 | Sticky flag for a byte programmed a third time |

## Verification
Corruption in the unlock tracker shows up in the cycle after the start request. Either `busy` fails to rise, or it rises and `seq_err` stays low where the key sequence should have been refused. A wrong timer count is seen at the falling edge of `busy` as a length other than PROG_CYCLES. A bad slot decode or row capture only appears once `done` is high, as wrong array bytes. A buffer that was wrongly cleared or overwritten during a commit is caught one commit later, because the bytes that were not rewritten read back wrong.

// File: rtl/flash_row_pkg.sv
// Package: flash_row_pkg
// Shared constants and types for the row-write controller.
// Assumes byte-wide data paths throughout.
package flash_row_pkg;
    typedef enum logic [1:0] {
        ULK_IDLE  = 2'd0,
        ULK_HALF  = 2'd1,
        ULK_ARMED = 2'd2
    } unlock_e;

    localparam logic [7:0] KEY_FIRST   = 8'h55;
    localparam logic [7:0] KEY_SECOND  = 8'hAA;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/unlock_tracker.sv
// Module: unlock_tracker
// Follows the two-byte unlock key and reports when it is complete.
// Any out-of-order key byte returns to idle. The disarm input has
// priority over key writes. The caller gates the inputs while a
// commit is in progress.
module unlock_tracker
    import flash_row_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_data,
    input  logic       disarm,
    output logic       armed
);
    unlock_e state_q;

    // Key state: the first byte always restarts, the second byte needs the first just before it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ULK_IDLE;
        end else if (disarm) begin
            state_q <= ULK_IDLE;
        end else if (key_we) begin
            if (key_data == KEY_FIRST)
                state_q <= ULK_HALF;
            else if (key_data == KEY_SECOND && state_q == ULK_HALF)
                state_q <= ULK_ARMED;
            else
                state_q <= ULK_IDLE;
        end
    end

    assign armed = (state_q == ULK_ARMED);
endmodule

// File: rtl/holding_buffer.sv
// Module: holding_buffer
// One row of byte registers, loaded one byte at a time by slot index.
// The contents are never cleared except by reset. The caller gates the
// write strobe while a commit is in progress.
module holding_buffer
    import flash_row_pkg::*;
#(
    parameter int ROW_BYTES = 64,
    parameter int IDX_W     = $clog2(ROW_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [7:0]             data,
    output logic [ROW_BYTES*8-1:0] row_bits
);
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_slot
        logic [7:0] byte_q;

        // Slot register: load when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= ERASED_BYTE;
            else if (we && idx == IDX_W'(g))
                byte_q <= data;
        end

        assign row_bits[g*8 +: 8] = byte_q;
    end
endmodule

// File: rtl/commit_sequencer.sv
// Module: commit_sequencer
// Times a commit with a cycle counter. It captures the target row at
// start, raises busy for PROG_CYCLES cycles, fires the commit strobe in
// the last busy cycle and pulses done once after that.
// Assumes PROG_CYCLES >= 2 and that start is never raised while busy.
module commit_sequencer #(
    parameter int PROG_CYCLES = 100000,
    parameter int ROW_W       = 3,
    localparam int CNT_W      = $clog2(PROG_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] row_in,
    output logic             busy,
    output logic             done,
    output logic             commit,
    output logic [ROW_W-1:0] row_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign commit = busy && (cnt_q == LAST);

    // Busy/timer/done control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            done <= commit;
            if (start) begin
                busy  <= 1'b1;
                cnt_q <= '0;
                row_q <= row_in;
            end else if (commit) begin
                busy  <= 1'b0;
            end else if (busy) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/row_array.sv
// Module: row_array
// Behavioural program-memory array with whole-row writes and an
// asynchronous byte read. It keeps a saturating 2-bit program count per
// byte and flags a third program. Erase is not modelled.
// Assumes ROWS and ROW_BYTES are powers of two.
module row_array
    import flash_row_pkg::*;
#(
    parameter int ROW_BYTES = 64,
    parameter int ROWS      = 8,
    parameter int IDX_W     = $clog2(ROW_BYTES),
    parameter int ROW_W     = $clog2(ROWS),
    localparam int ADDR_W   = IDX_W + ROW_W,
    localparam int DEPTH    = ROWS * ROW_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ROW_W-1:0]       wr_row,
    input  logic [ROW_BYTES*8-1:0] wr_bits,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [7:0]             rd_data,
    output logic                   overprog
);
    logic [7:0] mem_q    [DEPTH];
    logic [1:0] prog_cnt [DEPTH];

    // Row program: copy every byte, bump its count, flag a third program
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overprog <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i]    <= ERASED_BYTE;
                prog_cnt[i] <= 2'd0;
            end
        end else if (wr_en) begin
            for (int b = 0; b < ROW_BYTES; b++) begin
                mem_q[{wr_row, IDX_W'(b)}] <= wr_bits[b*8 +: 8];
                if (prog_cnt[{wr_row, IDX_W'(b)}] == 2'd2)
                    overprog <= 1'b1;
                else
                    prog_cnt[{wr_row, IDX_W'(b)}] <= prog_cnt[{wr_row, IDX_W'(b)}] + 2'd1;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/flash_row_writer.sv
// Module: flash_row_writer (top)
// Row-write sequencing controller. It stages bytes in a holding buffer,
// checks the unlock key and the enable bit, then stalls the processor
// while a timed commit copies the buffer into the row chosen by the
// upper pointer bits. All port writes are ignored while busy.
module flash_row_writer #(
    parameter int  ROW_BYTES   = 64,
    parameter int  ROWS        = 8,
    parameter int  PROG_CYCLES = 100000,
    localparam int IDX_W       = $clog2(ROW_BYTES),
    localparam int ROW_W       = $clog2(ROWS),
    localparam int ADDR_W      = IDX_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              buf_we,
    input  logic [7:0]        buf_data,
    input  logic              ctl_we,
    input  logic              ctl_wren,
    input  logic              ctl_wr,
    input  logic              key_we,
    input  logic [7:0]        key_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              stall,
    output logic              busy,
    output logic              done,
    output logic              seq_err,
    output logic              overprog
);
    logic                   armed;
    logic                   commit;
    logic [ROW_W-1:0]       commit_row;
    logic [ROW_BYTES*8-1:0] hold_bits;
    logic                   wr_req;
    logic                   start;

    assign wr_req = ctl_we && ctl_wr && !busy;
    assign start  = wr_req && armed && ctl_wren;
    assign stall  = busy;

    unlock_tracker u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (key_we && !busy),
        .key_data (key_data),
        .disarm   ((ctl_we || buf_we) && !busy),
        .armed    (armed)
    );

    holding_buffer #(.ROW_BYTES(ROW_BYTES), .IDX_W(IDX_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (buf_we && !busy),
        .idx      (ptr[IDX_W-1:0]),
        .data     (buf_data),
        .row_bits (hold_bits)
    );

    commit_sequencer #(.PROG_CYCLES(PROG_CYCLES), .ROW_W(ROW_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .row_in (ptr[ADDR_W-1:IDX_W]),
        .busy   (busy),
        .done   (done),
        .commit (commit),
        .row_q  (commit_row)
    );

    row_array #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS), .IDX_W(IDX_W), .ROW_W(ROW_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .wr_row   (commit_row),
        .wr_bits  (hold_bits),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .overprog (overprog)
    );

    // Sticky error: a start request refused for a missing key or a clear enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_err <= 1'b0;
        else if (wr_req && !(armed && ctl_wren))
            seq_err <= 1'b1;
    end
endmodule

// File: rtl/flash_row_writer_chk.sv
// Module: flash_row_writer_chk
// Port-level temporal checks for flash_row_writer, attached by bind.
// Measures the busy window with its own counter so that no deep $past
// is needed.
module flash_row_writer_chk #(
    parameter int PROG_CYCLES = 100000,
    parameter int ADDR_W      = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic              ctl_wr,
    input logic              ctl_wren,
    input logic              busy,
    input logic              done,
    input logic              seq_err,
    input logic              overprog,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data
);
    int unsigned busy_len;

    // Count the cycles of the current busy window
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_len <= 0;
        else if (busy)
            busy_len <= busy_len + 1;
        else
            busy_len <= 0;
    end

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_we && ctl_wr && ctl_wren));

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == PROG_CYCLES);

    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    seq_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    // R8
    overprog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overprog |=> overprog);

    // R7
    busy_array_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

bind flash_row_writer flash_row_writer_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .ADDR_W      (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_wr   (ctl_wr),
    .ctl_wren (ctl_wren),
    .busy     (busy),
    .done     (done),
    .seq_err  (seq_err),
    .overprog (overprog),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
);

// File: tb/flash_row_writer_tb_top.sv
`timescale 1ns/1ps
// Bench for flash_row_writer: directed corner cases plus seeded random
// row commits, checked against a bench-side model of buffer and array.
module flash_row_writer_tb_top;
    localparam int ROW_BYTES = 64;
    localparam int ROWS      = 8;
    localparam int PROG      = 20;
    localparam int ADDR_W    = 9;
    localparam int DEPTH     = ROWS * ROW_BYTES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] ptr = '0;
    logic buf_we = 1'b0;
    logic [7:0] buf_data = '0;
    logic ctl_we = 1'b0, ctl_wren = 1'b0, ctl_wr = 1'b0;
    logic key_we = 1'b0;
    logic [7:0] key_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic stall, busy, done, seq_err, overprog;

    always #10 clk = ~clk;

    flash_row_writer #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .ptr(ptr), .buf_we(buf_we), .buf_data(buf_data),
        .ctl_we(ctl_we), .ctl_wren(ctl_wren), .ctl_wr(ctl_wr),
        .key_we(key_we), .key_data(key_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .stall(stall), .busy(busy), .done(done), .seq_err(seq_err), .overprog(overprog)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] m_mem  [DEPTH];
    logic [7:0] m_hold [ROW_BYTES];
    int         m_cnt  [DEPTH];
    bit exp_seq = 0, exp_over = 0, m_busy = 0;

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(int row, int idx);
        return ADDR_W'(row * ROW_BYTES + idx);
    endfunction

    task automatic buf_wr(logic [ADDR_W-1:0] a, logic [7:0] d);
        ptr = a; buf_data = d; buf_we = 1'b1;
        @(negedge clk);
        buf_we = 1'b0;
        if (!m_busy) m_hold[a[5:0]] = d;
    endtask

    task automatic key_wr(logic [7:0] d);
        key_data = d; key_we = 1'b1;
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic ctl_write(bit wren, bit wr, logic [ADDR_W-1:0] p);
        ptr = p; ctl_wren = wren; ctl_wr = wr; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic read_chk(string tag, logic [ADDR_W-1:0] a);
        rd_addr = a;
        #1;
        check_eq(tag, rd_data, m_mem[a]);
    endtask

    task automatic start_commit(int row);
        key_wr(8'h55);
        key_wr(8'hAA);
        ctl_write(1'b1, 1'b1, mk_addr(row, $urandom_range(0, ROW_BYTES-1)));
        check_eq("R2 busy after start", busy, 1);
        check_eq("R2 stall after start", stall, 1);
        m_busy = 1;
    endtask

    task automatic finish_commit(int row, int elapsed);
        int cyc = elapsed;
        while (busy === 1'b1 && cyc < PROG + 5) begin
            cyc++;
            @(negedge clk);
        end
        check_eq("R4 busy length", cyc, PROG);
        check_eq("R4 done at end", done, 1);
        check_eq("R4 stall low at end", stall, 0);
        for (int b = 0; b < ROW_BYTES; b++) begin
            if (m_cnt[row*ROW_BYTES+b] == 2) exp_over = 1;
            else m_cnt[row*ROW_BYTES+b]++;
            m_mem[row*ROW_BYTES+b] = m_hold[b];
        end
        check_eq("R8 overprog", overprog, int'(exp_over));
        check_eq("R3 seq_err hold", seq_err, int'(exp_seq));
        for (int b = 0; b < ROW_BYTES; b++) read_chk("R5 row byte", mk_addr(row, b));
        @(negedge clk);
        check_eq("R4 done one cycle", done, 0);
        m_busy = 0;
    endtask

    task automatic run_commit(int row);
        start_commit(row);
        finish_commit(row, 0);
    endtask

    task automatic refused(string tag);
        check_eq({tag, " busy stays low"}, busy, 0);
        exp_seq = 1;
        check_eq({tag, " seq_err"}, seq_err, 1);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = 8'hFF; m_cnt[i] = 0; end
        for (int i = 0; i < ROW_BYTES; i++) m_hold[i] = 8'hFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check_eq("R9 busy", busy, 0);
        check_eq("R9 stall", stall, 0);
        check_eq("R9 done", done, 0);
        check_eq("R9 seq_err", seq_err, 0);
        check_eq("R9 overprog", overprog, 0);
        read_chk("R9 array erased", mk_addr(0, 0));
        read_chk("R9 array erased", mk_addr(7, 63));

        // R1 buffer loads leave the array alone
        for (int b = 0; b < ROW_BYTES; b++) buf_wr(mk_addr(2, b), 8'($urandom));
        check_eq("R1 busy idle", busy, 0);
        read_chk("R1 array untouched", mk_addr(2, 0));
        read_chk("R1 array untouched", mk_addr(2, 63));

        // R2 R4 R5 first commit to row 2
        run_commit(2);

        // R6 buffer kept: commit again to row 3 without reloading
        run_commit(3);
        rd_addr = mk_addr(3, 10);
        #1;
        check_eq("R6 stale byte reused", rd_data, m_hold[10]);

        // R3 refused start requests
        check_eq("R3 seq_err clear before", seq_err, 0);
        key_wr(8'h55); key_wr(8'h00); key_wr(8'hAA);
        ctl_write(1'b1, 1'b1, mk_addr(4, 0));
        refused("R3 broken key");
        key_wr(8'h55); key_wr(8'hAA); buf_wr(mk_addr(4, 1), 8'h3C);
        ctl_write(1'b1, 1'b1, mk_addr(4, 0));
        refused("R3 buffer write between");
        key_wr(8'h55); key_wr(8'hAA);
        ctl_write(1'b0, 1'b1, mk_addr(4, 0));
        refused("R3 wren clear");
        key_wr(8'h55); key_wr(8'hAA);
        ctl_write(1'b1, 1'b0, mk_addr(4, 0));
        ctl_write(1'b1, 1'b1, mk_addr(4, 0));
        refused("R3 control write between");
        read_chk("R3 row 4 untouched", mk_addr(4, 1));

        // R7 writes during busy are ignored
        start_commit(5);
        buf_wr(mk_addr(5, 0), 8'h77);
        key_wr(8'h55);
        key_wr(8'hAA);
        ctl_write(1'b1, 1'b1, mk_addr(6, 0));
        finish_commit(5, 4);
        ctl_write(1'b1, 1'b1, mk_addr(6, 0));
        check_eq("R7 unlock during busy not kept", busy, 0);
        run_commit(6);
        check_eq("R7 buffer write during busy dropped", rd_data == 8'h77 && m_hold[0] != 8'h77 ? 1 : 0, 0);
        read_chk("R7 slot 0 kept", mk_addr(6, 0));

        // R8 third program of row 2
        run_commit(2);
        check_eq("R8 no flag after second program", overprog, 0);
        run_commit(2);
        check_eq("R8 flag after third program", overprog, 1);

        // Random loads and commits
        for (int it = 0; it < 6; it++) begin
            int n = $urandom_range(1, 20);
            for (int k = 0; k < n; k++) buf_wr(ADDR_W'($urandom), 8'($urandom));
            run_commit($urandom_range(0, ROWS-1));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule